// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable, cycle-accurate model of a pipelined synchronous burst SRAM. Each word is 36 bits wide, in four 9-bit byte lanes. Lane i occupies bits [9i+8:9i]: eight data bits plus the lane's parity bit in the top position. The depth is set by a parameter. All control, address and write data are sampled on the rising clock edge. Read data comes out through a registered output stage. Because there is no bidirectional pad, the block drives a separate data-out bus together with a drive-enable flag.

An access starts when an address is loaded through one of two strobes:

- **Processor-side strobe.** It always starts a read.
- **Controller-side strobe.** It performs a read or a write, depending on the write controls of that cycle.

After a load, the internal burst counter either steps through four words or holds the current word as a wait state. Two step orders are available: linear and interleaved. A controller-side strobe with chip select high deselects the block.

A write can also follow a processor-side load on the next cycle. That write goes to the loaded address when the step input is held high.

Top module: `burst_sram`

## Requirements
- R1: During and after reset, and before any read, `dout_en_o` is low and `dout_o` is all zeros.
- R2: With `proc_ld_n_i` low and `sel_n_i` low, `addr_i` is loaded and a read of it starts, whatever the write controls and `ctl_ld_n_i` are. Memory is not changed in that cycle.
- R3: With `sel_n_i` high, a low `proc_ld_n_i` loads nothing. If `ctl_ld_n_i` is also high, the cycle acts as a continue or suspend of the current burst.
- R4: With `ctl_ld_n_i` low, `sel_n_i` low and `proc_ld_n_i` high, `addr_i` is loaded. A write is performed if one is requested, otherwise a read.
- R5: With `ctl_ld_n_i` low and `sel_n_i` high, the block deselects. `dout_en_o` is low from the second edge after that edge onward, and cycles without a strobe access nothing until the next load.
- R6: A write is requested when `wr_all_n_i` is low, or when `wr_en_n_i` is low and at least one bit of `lane_wr_n_i` is low.
  - With `wr_all_n_i` low, all four lanes are written.
  - With both `wr_all_n_i` and `wr_en_n_i` high, nothing is written.
- R7: Under a byte write, a low `lane_wr_n_i[i]` writes bits [9i+8:9i] of `din_i`, parity included. The other lanes keep their contents.
- R8: In a cycle with no strobe and `step_n_i` low during an active burst, the burst moves to its next address. The upper address bits stay fixed, and the count wraps after four words.
  - Linear order (`lin_burst_i` = 1): the low two bits are (base + count) mod 4.
  - Interleaved order (`lin_burst_i` = 0): the low two bits are base XOR count.
- R9: In a cycle with no strobe and `step_n_i` high during an active burst, the same address is accessed again.
- R10: After a processor-side load, a write requested on the next cycle goes to the loaded address if `step_n_i` is high, or to the next burst address if `step_n_i` is low.
- R11: `dout_en_o` is low after a write until a new read's data arrives. It is always low while `out_en_n_i` is high, and it follows `out_en_n_i` without waiting for a clock.
- R12: When both strobes are low with `sel_n_i` low, the processor-side rule wins: a read, with no write.
- R13: The data of a read whose address is taken at edge k appears on `dout_o` after edge k+1, with `dout_en_o` high if `out_en_n_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, taken on a load |
| din_i | input | 36 | Write data, four 9-bit lanes |
| sel_n_i | input | 1 | Chip select, active low, looked at on strobes |
| proc_ld_n_i | input | 1 | Processor-side load strobe, active low, always reads |
| ctl_ld_n_i | input | 1 | Controller-side load strobe, active low, reads or writes |
| step_n_i | input | 1 | Burst step, active low; high inserts a wait state |
| wr_all_n_i | input | 1 | Write all lanes, active low |
| wr_en_n_i | input | 1 | Byte write enable, active low |
| lane_wr_n_i | input | 4 | Per-lane write selects, active low |
| out_en_n_i | input | 1 | Output enable, active low, not clocked |
| lin_burst_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| dout_o | output | 36 | Read data, zero when not driven |
| dout_en_o | output | 1 | High when `dout_o` would be driven |

## Verification
The assertions check these properties on every cycle:
- a processor-side load, alone or together with the other strobe, is a read (R2, R12);
- with chip select high, neither strobe loads (R3);
- a deselect or a write turns the output off two edges later (R5, R11);
- every read's data is driven exactly two edges later under the output enable (R13);
- a full-width write enables all lanes (R6);
- a suspend reuses the previous address, and a continue changes only the low two bits (R8, R9).

Only the bench's scenarios can show the actual memory contents: lane-masked merging, the two burst orders and their wrap, the write that follows a processor-side load landing at the right address, and data returned after a deselect. The bench shows these by comparing every output against a reference model and against directed literal values.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  localparam int LANES   = 4;
  localparam int LANE_W  = 9;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Lanes a write would touch; zero means no write is requested.
  function automatic logic [LANES-1:0] lane_select(
    input logic             all_n,
    input logic             en_n,
    input logic [LANES-1:0] lane_n
  );
    logic [LANES-1:0] sel;
    if (!all_n)     sel = '1;
    else if (!en_n) sel = ~lane_n;
    else            sel = '0;
    return sel;
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_n_i,
  input  logic              proc_ld_n_i,
  input  logic              ctl_ld_n_i,
  input  logic              step_n_i,
  input  logic              wr_all_n_i,
  input  logic              wr_en_n_i,
  input  logic [LANES-1:0]  lane_wr_n_i,
  input  logic              lin_burst_i,
  output acc_e              acc_kind_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic              pld_o,
  output logic              cld_o,
  output logic              desel_o,
  output logic              cont_o,
  output logic              susp_o
);

  // Address of word 'cnt' in a burst starting at 'base'.
  function automatic logic [ADDR_W-1:0] seq_addr(
    input logic [ADDR_W-1:0]  base,
    input logic [BURST_W-1:0] cnt,
    input logic               lin
  );
    logic [BURST_W-1:0] low;
    if (lin) low = base[BURST_W-1:0] + cnt;
    else     low = base[BURST_W-1:0] ^ cnt;
    return {base[ADDR_W-1:BURST_W], low};
  endfunction

  logic               active_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nxt;
  logic [LANES-1:0]   req_lanes;
  logic               no_strobe;
  logic               inburst;

  assign pld_o     = !proc_ld_n_i && !sel_n_i;
  assign cld_o     = !ctl_ld_n_i && !sel_n_i && proc_ld_n_i;
  assign desel_o   = !ctl_ld_n_i && sel_n_i;
  assign no_strobe = ctl_ld_n_i && !pld_o;
  assign cont_o    = no_strobe && active_q && !step_n_i;
  assign susp_o    = no_strobe && active_q && step_n_i;
  assign inburst   = cont_o || susp_o;

  assign req_lanes = lane_select(wr_all_n_i, wr_en_n_i, lane_wr_n_i);
  assign cnt_nxt   = cont_o ? cnt_q + 1'b1 : cnt_q;

  always_comb begin
    if (pld_o)
      acc_kind_o = ACC_READ;
    else if ((cld_o || inburst) && (req_lanes != '0))
      acc_kind_o = ACC_WRITE;
    else if (cld_o || inburst)
      acc_kind_o = ACC_READ;
    else
      acc_kind_o = ACC_NONE;
  end

  assign acc_addr_o = (pld_o || cld_o) ? addr_i : seq_addr(base_q, cnt_nxt, lin_burst_i);
  assign lane_we_o  = (acc_kind_o == ACC_WRITE) ? req_lanes : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (pld_o || cld_o) begin
      active_q <= 1'b1;
      base_q   <= addr_i;
      cnt_q    <= '0;
    end else if (desel_o) begin
      active_q <= 1'b0;
    end else if (cont_o) begin
      cnt_q    <= cnt_nxt;
    end
  end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end

endmodule

// File: rtl/burst_sram_pipe.sv
module burst_sram_pipe #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic              out_en_n_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              dout_en_o
);

  logic              pend_q;
  logic              vld_q;
  logic [ADDR_W-1:0] raddr_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      vld_q   <= 1'b0;
      raddr_q <= '0;
      data_q  <= '0;
    end else begin
      data_q <= rdata_i;
      vld_q  <= pend_q;
      pend_q <= rd_req_i;
      if (rd_req_i) raddr_q <= rd_addr_i;
    end
  end

  assign raddr_o   = raddr_q;
  assign dout_en_o = vld_q && !out_en_n_i;
  assign dout_o    = dout_en_o ? data_q : '0;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = bsram_pkg::BURST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              sel_n_i,
  input  logic              proc_ld_n_i,
  input  logic              ctl_ld_n_i,
  input  logic              step_n_i,
  input  logic              wr_all_n_i,
  input  logic              wr_en_n_i,
  input  logic [LANES-1:0]  lane_wr_n_i,
  input  logic              out_en_n_i,
  input  logic              lin_burst_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              dout_en_o
);

  acc_e              acc_kind_w;
  logic [ADDR_W-1:0] acc_addr_w;
  logic [LANES-1:0]  lane_we_w;
  logic              pld_w;
  logic              cld_w;
  logic              desel_w;
  logic              cont_w;
  logic              susp_w;
  logic [ADDR_W-1:0] raddr_w;
  logic [WORD_W-1:0] rdata_w;
  logic              rd_req_w;

  assign rd_req_w = (acc_kind_w == ACC_READ);

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .sel_n_i    (sel_n_i),
    .proc_ld_n_i(proc_ld_n_i),
    .ctl_ld_n_i (ctl_ld_n_i),
    .step_n_i   (step_n_i),
    .wr_all_n_i (wr_all_n_i),
    .wr_en_n_i  (wr_en_n_i),
    .lane_wr_n_i(lane_wr_n_i),
    .lin_burst_i(lin_burst_i),
    .acc_kind_o (acc_kind_w),
    .acc_addr_o (acc_addr_w),
    .lane_we_o  (lane_we_w),
    .pld_o      (pld_w),
    .cld_o      (cld_w),
    .desel_o    (desel_w),
    .cont_o     (cont_w),
    .susp_o     (susp_w)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .lane_we_i(lane_we_w),
    .waddr_i  (acc_addr_w),
    .wdata_i  (din_i),
    .raddr_i  (raddr_w),
    .rdata_o  (rdata_w)
  );

  burst_sram_pipe #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req_i  (rd_req_w),
    .rd_addr_i (acc_addr_w),
    .raddr_o   (raddr_w),
    .rdata_i   (rdata_w),
    .out_en_n_i(out_en_n_i),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o)
  );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
  import bsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              pld_n,
  input logic              cld_n,
  input logic              oe_n,
  input logic              wall_n,
  input logic              dout_en,
  input logic [1:0]        acc_kind,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [LANES-1:0]  lane_we,
  input logic              pld,
  input logic              cld,
  input logic              desel,
  input logic              cont,
  input logic              susp
);

  logic [ADDR_W-1:0] prev_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_addr_q <= '0;
    else if (acc_kind != ACC_NONE) prev_addr_q <= acc_addr;
  end

  // R2 R12
  proc_load_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pld_n && !sel_n) |-> (acc_kind == ACC_READ));

  // R3
  unselected_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pld_n && sel_n && cld_n) |-> !(pld || cld));

  // R5
  desel_quiets_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel |-> ##2 !dout_en);

  // R11
  write_quiets_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_WRITE) |-> ##2 !dout_en);

  // R13
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_READ) |-> ##2 (dout_en == !oe_n));

  // R6
  full_write_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_kind == ACC_WRITE) && !wall_n) |-> (&lane_we));

  // R9
  suspend_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> (acc_addr == prev_addr_q));

  // R8
  continue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cont |-> ((acc_addr != prev_addr_q) &&
              (acc_addr[ADDR_W-1:BURST_W] == prev_addr_q[ADDR_W-1:BURST_W])));

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_n   (sel_n_i),
  .pld_n   (proc_ld_n_i),
  .cld_n   (ctl_ld_n_i),
  .oe_n    (out_en_n_i),
  .wall_n  (wr_all_n_i),
  .dout_en (dout_en_o),
  .acc_kind(acc_kind_w),
  .acc_addr(acc_addr_w),
  .lane_we (lane_we_w),
  .pld     (pld_w),
  .cld     (cld_w),
  .desel   (desel_w),
  .cont    (cont_w),
  .susp    (susp_w)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [35:0]   din;
  logic          sel_n, pld_n, cld_n, step_n, wall_n, wen_n, oe_n, lin;
  logic [3:0]    lane_n;
  logic [35:0]   dout;
  logic          dout_en;

  int checks = 0;
  int errors = 0;
  string cur_req = "R13";

  // reference model state
  logic [35:0]   ref_mem [NW];
  logic          m_act, m_pend, m_vld;
  logic [AW-1:0] m_base, m_raddr;
  logic [1:0]    m_cnt;
  logic [35:0]   m_data;

  always #4 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .din_i(din), .sel_n_i(sel_n),
    .proc_ld_n_i(pld_n), .ctl_ld_n_i(cld_n), .step_n_i(step_n),
    .wr_all_n_i(wall_n), .wr_en_n_i(wen_n), .lane_wr_n_i(lane_n),
    .out_en_n_i(oe_n), .lin_burst_i(lin), .dout_o(dout), .dout_en_o(dout_en)
  );

  function automatic logic [35:0] pat(input int i);
    return {4{9'(i * 7 + 3)}} ^ 36'h5A5A5A5A5;
  endfunction

  function automatic logic [AW-1:0] next_in_burst(input logic [AW-1:0] b, input logic [1:0] c, input logic l);
    logic [1:0] lo;
    lo = l ? 2'(b[1:0] + c) : (b[1:0] ^ c);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [3:0] want_lanes(input logic a_n, input logic e_n, input logic [3:0] l_n);
    if (a_n == 1'b0) return 4'hF;
    if (e_n == 1'b0) return ~l_n;
    return 4'h0;
  endfunction

  task automatic model_access(input logic [AW-1:0] a);
    logic [3:0] m;
    m = want_lanes(wall_n, wen_n, lane_n);
    if (m != 4'h0) begin
      for (int k = 0; k < 4; k++)
        if (m[k]) ref_mem[a][k*9 +: 9] = din[k*9 +: 9];
      m_pend = 1'b0;
    end else begin
      m_pend = 1'b1;
      m_raddr = a;
    end
  endtask

  task automatic model_edge();
    m_data = ref_mem[m_raddr];
    m_vld  = m_pend;
    if (!pld_n && !sel_n) begin
      m_act = 1'b1; m_base = addr; m_cnt = 2'd0;
      m_pend = 1'b1; m_raddr = addr;
    end else if (!cld_n && sel_n) begin
      m_act = 1'b0; m_pend = 1'b0;
    end else if (!cld_n) begin
      m_act = 1'b1; m_base = addr; m_cnt = 2'd0;
      model_access(addr);
    end else if (m_act) begin
      if (!step_n) m_cnt = m_cnt + 2'd1;
      model_access(next_in_burst(m_base, m_cnt, lin));
    end else begin
      m_pend = 1'b0;
    end
  endtask

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    logic        e_en;
    logic [35:0] e_d;
    e_en = m_vld && !oe_n;
    e_d  = e_en ? m_data : 36'h0;
    chk(cur_req, {35'h0, dout_en}, {35'h0, e_en});
    chk(cur_req, dout, e_d);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_model();
  endtask

  task automatic quiet();
    pld_n = 1; cld_n = 1; sel_n = 1; step_n = 1;
    wall_n = 1; wen_n = 1; lane_n = 4'hF; oe_n = 0;
  endtask

  task automatic ctl_access(input logic [AW-1:0] a, input logic [35:0] d,
                            input logic a_n, input logic e_n, input logic [3:0] l_n);
    quiet(); cld_n = 0; sel_n = 0; addr = a; din = d;
    wall_n = a_n; wen_n = e_n; lane_n = l_n;
    tick();
    quiet();
  endtask

  task automatic desel();
    quiet(); cld_n = 0; sel_n = 1;
    tick();
    quiet();
  endtask

  // read a word through the controller strobe; result visible after the deselect edge
  task automatic read_word(input logic [AW-1:0] a, output logic [35:0] q);
    ctl_access(a, 36'h0, 1, 1, 4'hF);
    desel();
    q = dout;
  endtask

  task automatic burst_step(input logic s_n);
    quiet(); step_n = s_n;
    tick();
  endtask

  logic [35:0] q;
  logic [35:0] merged;
  logic [63:0] r64;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 0; addr = '0; din = '0; lin = 1; quiet();
    m_act = 0; m_pend = 0; m_vld = 0; m_data = '0; m_raddr = '0; m_base = '0; m_cnt = '0;
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {35'h0, dout_en}, 36'h0);
    chk("R1", dout, 36'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {35'h0, dout_en}, 36'h0);

    // preload via full-width controller writes (R4, R6)
    cur_req = "R4";
    for (int i = 0; i < NW; i++) ctl_access(AW'(i), pat(i), 0, 1, 4'hF);

    // R13 latency: one edge after the read edge nothing yet
    cur_req = "R13";
    ctl_access(5, 36'h0, 1, 1, 4'hF);
    chk("R13", {35'h0, dout_en}, 36'h0);
    desel();
    chk("R4", dout, pat(5));
    // R5 output off after deselect, idle cycles access nothing
    cur_req = "R5";
    desel();
    chk("R5", {35'h0, dout_en}, 36'h0);
    burst_step(0);
    chk("R5", {35'h0, dout_en}, 36'h0);

    // R7 single-lane write of lane 1 (bits 17:9)
    cur_req = "R7";
    ctl_access(5, 36'hFFFFFFFFF, 1, 0, 4'b1101);
    merged = pat(5) | (36'h1FF << 9);
    read_word(5, q);
    chk("R7", q, merged);
    // R6 no write when both write enables high, or lanes all high
    cur_req = "R6";
    ctl_access(5, 36'h0, 1, 1, 4'h0);
    ctl_access(5, 36'h0, 1, 0, 4'hF);
    read_word(5, q);
    chk("R6", q, merged);
    ctl_access(5, 36'h123456789, 0, 1, 4'hF);
    read_word(5, q);
    chk("R6", q, 36'h123456789);

    // R8 linear burst from 9: 9,10,11,8 then wrap to 9
    cur_req = "R8";
    lin = 1;
    ctl_access(9, 36'h0, 1, 1, 4'hF);
    burst_step(0); chk("R8", dout, pat(9));
    burst_step(0); chk("R8", dout, pat(10));
    burst_step(0); chk("R8", dout, pat(11));
    burst_step(0); chk("R8", dout, pat(8));
    desel();       chk("R8", dout, pat(9));
    // R8 interleaved from 9: 9,8,11,10 then 9
    lin = 0;
    ctl_access(9, 36'h0, 1, 1, 4'hF);
    burst_step(0); chk("R8", dout, pat(9));
    burst_step(0); chk("R8", dout, pat(8));
    burst_step(0); chk("R8", dout, pat(11));
    burst_step(0); chk("R8", dout, pat(10));
    desel();       chk("R8", dout, pat(9));
    lin = 1;

    // R9 suspend repeats the address
    cur_req = "R9";
    ctl_access(20, 36'h0, 1, 1, 4'hF);
    burst_step(1); chk("R9", dout, pat(20));
    burst_step(1); chk("R9", dout, pat(20));
    desel();       chk("R9", dout, pat(20));

    // R2 / R10 processor load ignores write controls, next-cycle write hits loaded address
    cur_req = "R10";
    quiet(); pld_n = 0; sel_n = 0; addr = 12; wall_n = 0; din = 36'h0;
    tick();
    quiet(); wall_n = 0; din = 36'hABCDE1234;
    tick();
    chk("R2", dout, pat(12));
    desel();
    read_word(12, q);
    chk("R10", q, 36'hABCDE1234);
    quiet(); pld_n = 0; sel_n = 0; addr = 13;
    tick();
    quiet(); step_n = 0; wall_n = 0; din = 36'h0F0F0F0F0;
    tick();
    desel();
    read_word(13, q); chk("R10", q, pat(13));
    read_word(14, q); chk("R10", q, 36'h0F0F0F0F0);

    // R12 both strobes low: read, no write
    cur_req = "R12";
    quiet(); pld_n = 0; cld_n = 0; sel_n = 0; addr = 30; wall_n = 0; din = 36'h0;
    tick();
    desel();
    chk("R12", dout, pat(30));
    read_word(30, q);
    chk("R12", q, pat(30));

    // R3 processor strobe with select high acts as suspend of the burst at 40
    cur_req = "R3";
    ctl_access(40, 36'h0, 1, 1, 4'hF);
    quiet(); pld_n = 0; sel_n = 1; addr = 41;
    tick();
    desel();
    chk("R3", dout, pat(40));

    // R11 output off after writes; output enable gates without a clock
    cur_req = "R11";
    ctl_access(50, 36'h777777777, 0, 1, 4'hF);
    quiet(); wall_n = 0; din = 36'h777777777;
    tick();
    chk("R11", {35'h0, dout_en}, 36'h0);
    desel();
    chk("R11", {35'h0, dout_en}, 36'h0);
    ctl_access(50, 36'h0, 1, 1, 4'hF);
    quiet(); cld_n = 0; sel_n = 1; oe_n = 1;
    tick();
    chk("R11", {35'h0, dout_en}, 36'h0);
    chk("R11", dout, 36'h0);
    oe_n = 0;
    #1;
    chk("R11", {35'h0, dout_en}, 36'h1);
    chk("R11", dout, 36'h777777777);
    @(negedge clk);
    quiet();
    desel();

    // constrained random traffic checked against the model
    cur_req = "R13";
    for (int blk = 0; blk < 2; blk++) begin
      desel();
      lin = (blk == 0);
      for (int n = 0; n < 1500; n++) begin
        pld_n  = ($urandom % 5) != 0;
        cld_n  = ($urandom % 4) != 0;
        sel_n  = ($urandom % 6) == 0;
        step_n = $urandom % 2;
        wall_n = ($urandom % 4) != 0;
        wen_n  = $urandom % 2;
        lane_n = 4'($urandom);
        oe_n   = ($urandom % 5) == 0;
        addr   = AW'($urandom);
        r64    = {$urandom, $urandom};
        din    = r64[35:0];
        tick();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule